// File: doc/BRIEF.md
# Dual-Mode Flash Bus Interface

This block is the device-side front end of a parallel NOR-style flash memory. It registers the asynchronous control pins into the system clock domain: chip select, output enable, write enable, the hardware reset pin, the byte/word mode pin and the write-protect pin, together with the address and the incoming data bus. From these registered pins it builds the array address and the output enables for the two data-bus byte lanes. It also turns a qualified bus write into a single-cycle internal strobe that carries the captured byte or word address and data.

A second job is program/erase permission. A stored protection bit is kept for each sector and is loaded through a side port. A low write-protect pin also blocks the two boot sectors at the end of the sector range chosen by a build parameter. An open-drain-style ready/busy pull-down follows the busy flag of the internal program/erase engine. The command decoder and the array sit behind this block and use its strobe, address and permission outputs.

Top module: `flash_bus_front`

## Requirements
- R1: Word read. When the registered pins show chip select low, output enable low and mode pin high, both lane enables (`dq_oe_lo`, `dq_oe_hi`) are 1, `dq_out` equals `rd_data`, and `arr_addr` equals the registered address. This holds in the cycle after the clock edge that sampled the pins.
- R2: Byte read. When the mode pin is registered low, only the low lane is enabled (`dq_oe_hi` = 0). `dq_out[7:0]` carries `rd_data[15:8]` when the registered `dq_in[15]` (the byte-address LSB) is 1, and `rd_data[7:0]` when it is 0.
- R3: With chip select registered high, `standby` is 1, neither lane is enabled and no write strobe is produced.
- R4: With output enable registered high, neither lane is enabled, whatever the other pins show.
- R5: A write is qualified only while chip select is low, output enable is high and write enable is low, all as registered. `wr_pulse` is high for exactly one cycle for each continuous qualified interval. It appears in the cycle after the second clock edge, counting from the edge that first samples the qualified state.
- R6: Each write strobe carries the pins sampled at the start of the interval. In word mode `wr_addr` = {addr, 0}, `wr_data` = dq_in and `wr_byte` = 0. In byte mode `wr_addr` = {addr, dq_in[15]}, `wr_data` = {8'h00, dq_in[7:0]} and `wr_byte` = 1.
- R7: While `rst_n` is low, both lanes are off, `standby` is 1, `wr_pulse` is 0 and writes presented on the pins are ignored. After release, the pins are sampled afresh and reads work again.
- R8: A `prot_wr` cycle with `prot_sel` < NUM_SECT stores `prot_set` as the protection bit of that sector from the next cycle on. `sect_allow[i]` is 0 when the stored bit of sector i is 1. The stored bits are not cleared by `rst_n`.
- R9: With the registered `wp_n` low, `sect_allow` is 0 for the two boot sectors. These are sectors 0 and 1 when BOOT_TOP = 0, and NUM_SECT-2 and NUM_SECT-1 when BOOT_TOP = 1. All other sectors follow their stored bit, and the boot sectors also follow their stored bit when `wp_n` is high.
- R10: `ryby_pull_low` is 1 exactly while `busy` is 1.
- R11: The mode pin is sampled again for every access, so a read or write right after a mode change uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| ce_n | input | 1 | Chip select pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| byte_n | input | 1 | Mode pin: low selects byte mode, high selects word mode |
| wp_n | input | 1 | Boot-sector write-protect pin, active low |
| addr | input | AW (21) | Word address pins |
| dq_in | input | 16 | Data bus input; bit 15 is the byte-address LSB in byte mode |
| rd_data | input | 16 | Word read from the array at `arr_addr` |
| busy | input | 1 | Program/erase engine active |
| prot_wr | input | 1 | Load strobe for a stored protection bit |
| prot_sel | input | SW (7) | Sector index for the load |
| prot_set | input | 1 | Protection value to store |
| arr_addr | output | AW (21) | Registered word address to the array |
| dq_out | output | 16 | Data bus output value |
| dq_oe_lo | output | 1 | Drive enable for lane [7:0] |
| dq_oe_hi | output | 1 | Drive enable for lane [15:8] |
| standby | output | 1 | Device deselected or held in reset |
| wr_pulse | output | 1 | Single-cycle internal write strobe |
| wr_addr | output | AW+1 (22) | Captured byte address of the write |
| wr_data | output | 16 | Captured write data |
| wr_byte | output | 1 | Captured write was in byte mode |
| sect_allow | output | NUM_SECT (71) | Per-sector program/erase permission |
| ryby_pull_low | output | 1 | Pull-down enable of the ready/busy pin |

## Verification
The bench builds two copies side by side with the default 21-bit address and 71 sectors. One copy uses BOOT_TOP = 1 and the other BOOT_TOP = 0. Both copies get identical pin traffic, so a single write-protect sweep checks the top-boot pair (69, 70) and the bottom-boot pair (0, 1) against the same stored pattern. The full 71-bit sector range also reaches the last valid load index, and a load at an index past it must be ignored.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
    localparam int DQ_W   = 16;
    localparam int HALF_W = DQ_W / 2;

    typedef struct packed {
        logic            ce_n;
        logic            oe_n;
        logic            we_n;
        logic            byte_n;
        logic            wp_n;
        logic [DQ_W-1:0] dq;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                    byte_n: 1'b1, wp_n: 1'b0, dq: '0};
endpackage

// File: rtl/fbi_pin_sampler.sv
module fbi_pin_sampler
    import fbi_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pins_t         pins_in,
    input  logic [AW-1:0] addr_in,
    output pins_t         pins_q,
    output logic [AW-1:0] addr_q
);
    typedef struct packed {
        pins_t         p;
        logic [AW-1:0] a;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.p = pins_in;
        s_d.a = addr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.p <= PINS_IDLE;
            s_q.a <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pins_q = s_q.p;
    assign addr_q = s_q.a;
endmodule

// File: rtl/fbi_write_qual.sv
module fbi_write_qual
    import fbi_pkg::*;
#(
    parameter int AW = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pins_t           pins,
    input  logic [AW-1:0]   addr,
    output logic            wr_pulse,
    output logic [AW:0]     wr_addr,
    output logic [DQ_W-1:0] wr_data,
    output logic            wr_byte
);
    typedef struct packed {
        logic            prev;
        logic            pulse;
        logic [AW:0]     waddr;
        logic [DQ_W-1:0] wdata;
        logic            wbyte;
    } wq_t;

    wq_t  w_d, w_q;
    logic qual;
    logic bmode;

    assign bmode = ~pins.byte_n;
    assign qual  = ~pins.ce_n & pins.oe_n & ~pins.we_n;

    always_comb begin
        w_d       = w_q;
        w_d.prev  = qual;
        w_d.pulse = qual & ~w_q.prev;
        if (qual && !w_q.prev) begin
            w_d.wbyte = bmode;
            if (bmode) begin
                w_d.waddr = {addr, pins.dq[DQ_W-1]};
                w_d.wdata = {{HALF_W{1'b0}}, pins.dq[HALF_W-1:0]};
            end else begin
                w_d.waddr = {addr, 1'b0};
                w_d.wdata = pins.dq;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wr_pulse = w_q.pulse;
    assign wr_addr  = w_q.waddr;
    assign wr_data  = w_q.wdata;
    assign wr_byte  = w_q.wbyte;
endmodule

// File: rtl/fbi_sector_guard.sv
module fbi_sector_guard #(
    parameter int NUM_SECT = 71,
    parameter bit BOOT_TOP = 1'b0,
    localparam int SW      = $clog2(NUM_SECT),
    localparam int BOOT_LO = BOOT_TOP ? NUM_SECT - 2 : 0
) (
    input  logic                clk,
    input  logic                prot_wr,
    input  logic [SW-1:0]       prot_sel,
    input  logic                prot_set,
    input  logic                wp_n,
    output logic [NUM_SECT-1:0] allow
);
    logic [NUM_SECT-1:0] prot_d, prot_q;

    always_comb begin
        prot_d = prot_q;
        if (prot_wr && (int'(prot_sel) < NUM_SECT))
            prot_d[prot_sel] = prot_set;
    end

    // Stored protection is kept across the reset pin on purpose.
    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
        if (i == BOOT_LO || i == BOOT_LO + 1) begin : g_boot
            assign allow[i] = ~(prot_q[i] | ~wp_n);
        end else begin : g_plain
            assign allow[i] = ~prot_q[i];
        end
    end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import fbi_pkg::*;
#(
    parameter int AW       = 21,
    parameter int NUM_SECT = 71,
    parameter bit BOOT_TOP = 1'b0,
    localparam int SW      = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic                byte_n,
    input  logic                wp_n,
    input  logic [AW-1:0]       addr,
    input  logic [DQ_W-1:0]     dq_in,
    input  logic [DQ_W-1:0]     rd_data,
    input  logic                busy,
    input  logic                prot_wr,
    input  logic [SW-1:0]       prot_sel,
    input  logic                prot_set,
    output logic [AW-1:0]       arr_addr,
    output logic [DQ_W-1:0]     dq_out,
    output logic                dq_oe_lo,
    output logic                dq_oe_hi,
    output logic                standby,
    output logic                wr_pulse,
    output logic [AW:0]         wr_addr,
    output logic [DQ_W-1:0]     wr_data,
    output logic                wr_byte,
    output logic [NUM_SECT-1:0] sect_allow,
    output logic                ryby_pull_low
);
    pins_t pins_raw, pins_q;
    logic  rd_en;
    logic  lane_up;

    assign pins_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                        byte_n: byte_n, wp_n: wp_n, dq: dq_in};

    fbi_pin_sampler #(.AW(AW)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_raw),
        .addr_in (addr),
        .pins_q  (pins_q),
        .addr_q  (arr_addr)
    );

    fbi_write_qual #(.AW(AW)) u_wq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins_q),
        .addr     (arr_addr),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_byte  (wr_byte)
    );

    fbi_sector_guard #(.NUM_SECT(NUM_SECT), .BOOT_TOP(BOOT_TOP)) u_guard (
        .clk      (clk),
        .prot_wr  (prot_wr),
        .prot_sel (prot_sel),
        .prot_set (prot_set),
        .wp_n     (pins_q.wp_n),
        .allow    (sect_allow)
    );

    // Reset pin gates the bus directly so it floats without waiting for a clock.
    assign rd_en    = rst_n & ~pins_q.ce_n & ~pins_q.oe_n;
    assign dq_oe_lo = rd_en;
    assign dq_oe_hi = rd_en & pins_q.byte_n;
    assign standby  = ~rst_n | pins_q.ce_n;
    assign lane_up  = ~pins_q.byte_n & pins_q.dq[DQ_W-1];

    always_comb begin
        dq_out = rd_data;
        if (lane_up) dq_out[HALF_W-1:0] = rd_data[DQ_W-1:HALF_W];
    end

    assign ryby_pull_low = busy;
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk #(
    parameter int NUM_SECT = 71,
    parameter bit BOOT_TOP = 1'b0,
    localparam int BOOT_LO = BOOT_TOP ? NUM_SECT - 2 : 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ce_n,
    input logic                oe_n,
    input logic                we_n,
    input logic                wp_n,
    input logic                standby,
    input logic                dq_oe_lo,
    input logic                dq_oe_hi,
    input logic                wr_pulse,
    input logic [NUM_SECT-1:0] sect_allow
);
    // R3: a deselected device drives no lane
    a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!dq_oe_lo && !dq_oe_hi));

    // R2: the upper lane is never driven alone
    a_r2_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_hi |-> dq_oe_lo);

    // R5: the write strobe lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R5: a strobe traces back to a qualified pin state two edges earlier
    a_r5_pulse_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(!ce_n && oe_n && !we_n, 2));

    // R9: a low protect pin blocks both boot sectors
    a_r9_boot_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wp_n) |-> (!sect_allow[BOOT_LO] && !sect_allow[BOOT_LO+1]));

    // R7: reset floats the bus and kills strobes
    always_comb begin
        if (!rst_n) begin
            a_r7_reset_quiet: assert (standby && !dq_oe_lo && !dq_oe_hi && !wr_pulse);
        end
    end
endmodule

bind flash_bus_front flash_bus_front_chk #(.NUM_SECT(NUM_SECT), .BOOT_TOP(BOOT_TOP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .wp_n       (wp_n),
    .standby    (standby),
    .dq_oe_lo   (dq_oe_lo),
    .dq_oe_hi   (dq_oe_hi),
    .wr_pulse   (wr_pulse),
    .sect_allow (sect_allow)
);

// File: tb/flash_bus_front_tb.sv
`timescale 1ns/1ps
module flash_bus_front_tb;
    localparam int AW = 21;
    localparam int NS = 71;
    localparam int SW = $clog2(NS);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic byte_n = 1'b1, wp_n = 1'b1, busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_in = '0, rd_data = '0;
    logic prot_wr = 1'b0, prot_set = 1'b0;
    logic [SW-1:0] prot_sel = '0;

    logic [AW-1:0] arr_addr, arr_addr_b;
    logic [15:0] dq_out, dq_out_b, wr_data, wr_data_b;
    logic oe_lo, oe_hi, stby, wpul, wbyte, ryby;
    logic oe_lo_b, oe_hi_b, stby_b, wpul_b, wbyte_b, ryby_b;
    logic [AW:0] wr_addr, wr_addr_b;
    logic [NS-1:0] allow_t, allow_b;

    flash_bus_front #(.AW(AW), .NUM_SECT(NS), .BOOT_TOP(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_n(byte_n), .wp_n(wp_n), .addr(addr), .dq_in(dq_in),
        .rd_data(rd_data), .busy(busy), .prot_wr(prot_wr), .prot_sel(prot_sel),
        .prot_set(prot_set), .arr_addr(arr_addr), .dq_out(dq_out),
        .dq_oe_lo(oe_lo), .dq_oe_hi(oe_hi), .standby(stby), .wr_pulse(wpul),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_byte(wbyte),
        .sect_allow(allow_t), .ryby_pull_low(ryby));

    flash_bus_front #(.AW(AW), .NUM_SECT(NS), .BOOT_TOP(1'b0)) u_dut_bot (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_n(byte_n), .wp_n(wp_n), .addr(addr), .dq_in(dq_in),
        .rd_data(rd_data), .busy(busy), .prot_wr(prot_wr), .prot_sel(prot_sel),
        .prot_set(prot_set), .arr_addr(arr_addr_b), .dq_out(dq_out_b),
        .dq_oe_lo(oe_lo_b), .dq_oe_hi(oe_hi_b), .standby(stby_b), .wr_pulse(wpul_b),
        .wr_addr(wr_addr_b), .wr_data(wr_data_b), .wr_byte(wbyte_b),
        .sect_allow(allow_b), .ryby_pull_low(ryby_b));

    // ---------------- reference model ----------------
    logic m_ce, m_oe, m_we, m_bn, m_wp, m_prev, m_pulse, m_wb, wqn;
    logic [15:0] m_dq, m_wd;
    logic [AW-1:0] m_a;
    logic [AW:0] m_wa;
    logic [NS-1:0] m_prot = '0;
    logic loaded = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ce = 1; m_oe = 1; m_we = 1; m_bn = 1; m_wp = 0; m_dq = '0; m_a = '0;
            m_prev = 0; m_pulse = 0; m_wa = '0; m_wd = '0; m_wb = 0;
        end else begin
            wqn = (m_ce == 0) && (m_oe == 1) && (m_we == 0);
            m_pulse = wqn && !m_prev;
            if (m_pulse) begin
                m_wb = !m_bn;
                m_wa = m_bn ? {m_a, 1'b0} : {m_a, m_dq[15]};
                m_wd = m_bn ? m_dq : {8'h00, m_dq[7:0]};
            end
            m_prev = wqn;
            m_ce = ce_n; m_oe = oe_n; m_we = we_n; m_bn = byte_n;
            m_wp = wp_n; m_dq = dq_in; m_a = addr;
        end
    end

    always @(posedge clk) begin
        if (prot_wr && (int'(prot_sel) < NS)) m_prot[prot_sel] = prot_set;
    end

    // ---------------- comparison ----------------
    int vectors = 0, misses = 0;
    string phase = "R7";

    task automatic chk(string f, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", phase, f, act, exp, $time);
        end
    endtask

    function automatic logic [NS-1:0] exp_allow(bit top);
        logic [NS-1:0] r;
        int lo;
        lo = top ? NS - 2 : 0;
        for (int i = 0; i < NS; i++)
            r[i] = !(m_prot[i] || ((i == lo || i == lo + 1) && !m_wp));
        return r;
    endfunction

    always @(negedge clk) begin
        logic rd, e_hi;
        logic [15:0] e_dq;
        rd   = rst_n && !m_ce && !m_oe;
        e_hi = rd && m_bn;
        e_dq = rd_data;
        if (!m_bn && m_dq[15]) e_dq[7:0] = rd_data[15:8];
        chk("R1 lanes", {oe_lo, oe_hi, oe_lo_b, oe_hi_b}, {rd, e_hi, rd, e_hi});
        chk("R1 arr_addr", {arr_addr, arr_addr_b}, {m_a, m_a});
        if (rd) chk("R2 dq_out", {dq_out, dq_out_b}, {e_dq, e_dq});
        chk("R3 standby", {stby, stby_b}, {2{!rst_n || m_ce}});
        chk("R5 wr_pulse", {wpul, wpul_b}, {2{m_pulse}});
        chk("R6 wr fields", {wr_addr, wr_data, wbyte}, {m_wa, m_wd, m_wb});
        chk("R10 ryby", {ryby, ryby_b}, {2{busy}});
        if (loaded) begin
            chk("R9 allow top", allow_t, exp_allow(1'b1));
            chk("R9 allow bot", allow_b, exp_allow(1'b0));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #4;
    endtask

    task automatic bus(logic c, logic o, logic w, logic b, logic [AW-1:0] a,
                       logic [15:0] d, logic [15:0] r);
        ce_n = c; oe_n = o; we_n = w; byte_n = b; addr = a; dq_in = d; rd_data = r;
    endtask

    initial begin
        #(20 * 100000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R7: reset state, write attempt ignored while held
        phase = "R7";
        bus(0, 1, 0, 1, 21'h1234, 16'hBEEF, 16'h5555);
        step(3);
        bus(0, 0, 1, 1, 21'h0ABC, 16'h0, 16'hA5C3);
        step(2);
        rst_n = 1'b1;
        step(2);

        // R1: word reads over several patterns
        phase = "R1";
        for (int i = 0; i < 6; i++) begin
            bus(0, 0, 1, 1, 21'h100 * i + 21'h0F, 16'h0, 16'h1111 * i + 16'h0F0F);
            step(1);
        end

        // R2 / R11: byte reads, mode swapped per access
        phase = "R2";
        for (int i = 0; i < 6; i++) begin
            bus(0, 0, 1, 0, 21'h20 + i, {i[0], 15'h0}, 16'hC33C ^ (16'h0101 * i));
            step(1);
        end
        phase = "R11";
        for (int i = 0; i < 6; i++) begin
            bus(0, 0, 1, i[0], 21'h40 + i, 16'h8000, 16'h9A7E);
            step(1);
        end

        // R4: output enable high keeps bus off
        phase = "R4";
        bus(0, 1, 1, 1, 21'h77, 16'h0, 16'hFFFF);
        step(3);
        // R3: deselected, read and write attempts both ignored
        phase = "R3";
        bus(1, 0, 1, 1, 21'h78, 16'h0, 16'hFFFF);
        step(2);
        bus(1, 1, 0, 1, 21'h79, 16'h1234, 16'h0);
        step(3);

        // R5 / R6: word write, long strobe gives one pulse
        phase = "R5";
        bus(0, 1, 0, 1, 21'h1ABCD, 16'h3C5A, 16'h0);
        step(5);
        bus(0, 1, 1, 1, 21'h1ABCD, 16'h3C5A, 16'h0);
        step(2);
        phase = "R6";
        bus(0, 1, 0, 0, 21'h0F0F0, 16'h80E7, 16'h0);
        step(1);
        bus(0, 1, 1, 0, 21'h0F0F0, 16'h80E7, 16'h0);
        step(2);
        bus(0, 1, 0, 0, 21'h00003, 16'h7F18, 16'h0);
        step(1);
        bus(0, 1, 1, 1, 21'h00003, 16'h0, 16'h0);
        step(3);
        // R5: write enable low with output enable low is not a write
        phase = "R5";
        bus(0, 0, 0, 1, 21'h55, 16'h1111, 16'h2222);
        step(3);
        bus(1, 1, 1, 1, 21'h0, 16'h0, 16'h0);
        step(2);

        // R8: load a pattern, plus an out-of-range index
        phase = "R8";
        for (int i = 0; i < NS; i++) begin
            prot_wr = 1'b1; prot_sel = SW'(i); prot_set = (i % 3 == 1);
            step(1);
        end
        prot_sel = SW'(NS + 3); prot_set = 1'b1;
        step(1);
        prot_wr = 1'b0;
        step(1);
        loaded = 1'b1;
        step(2);

        // R9: protect pin sweeps, stored values on boot sectors varied
        phase = "R9";
        wp_n = 1'b0; step(3);
        wp_n = 1'b1; step(2);
        prot_wr = 1'b1; prot_sel = SW'(0);  prot_set = 1'b1; step(1);
        prot_sel = SW'(70); prot_set = 1'b1; step(1);
        prot_sel = SW'(69); prot_set = 1'b0; step(1);
        prot_wr = 1'b0; step(2);
        wp_n = 1'b0; step(2);
        wp_n = 1'b1; step(2);

        // R10: busy toggles
        phase = "R10";
        for (int i = 0; i < 5; i++) begin
            busy = i[0]; step(1);
        end
        busy = 1'b0;

        // R7: reset mid-write, protection survives, reads resume
        phase = "R7";
        bus(0, 1, 0, 1, 21'h2222, 16'hABCD, 16'h0);
        step(1);
        rst_n = 1'b0;
        step(3);
        bus(0, 0, 1, 1, 21'h3333, 16'h0, 16'h6A6A);
        step(1);
        rst_n = 1'b1;
        step(3);
        bus(1, 1, 1, 1, 21'h0, 16'h0, 16'h0);
        step(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule